// File: doc/BRIEF.md
# Serial Command Word Receiver with Chained Output

This block is the three-wire serial front end of a dual-channel converter control core. A host drives a serial clock, a data line and an active-low select. The block oversamples all three with a fast system clock, collects a 16-bit command word most significant bit first, and hands the word to the command decoder with a one-cycle execute strobe when the select line is released. It also drives a serial data output taken from the end of its shift register, so several receivers can be chained on one data line.

The output launch edge is picked by a mode input that comes from the command decoder. In falling-launch mode the chained output changes on serial clock falling edges, which gives a 16-clock lag. In rising-launch mode it changes on rising edges, which gives a 15.5-clock lag. The word output is a stream with a valid flag and no ready: the strobe cannot be held off, so the decoder must take the word in the cycle the strobe is high.

The system clock must run at least four times faster than the serial clock. The serial clock high and low phases must each last at least two system clocks.

Top module: `serial_cmd_rx`

## Requirements
- R1: Frame bit order: the first bit sent lands in word_o[15] (address bit), the next two in word_o[14:13] (control bits), and the last thirteen in word_o[12:0] (data, most significant first).
- R2: While the synchronized select is high, serial clock edges are ignored. The shift register keeps its value, which is visible on dout_o in rising-launch mode, and the bit count does not advance.
- R3: While the select is low, din_i is captured into the shift register on every rising edge of the serial clock.
- R4: On a rising edge of the select, word_valid_o is high for exactly one system clock, a few clocks after the edge and only while the synchronized select is high. word_o holds the word in that cycle.
- R5: If more than 16 rising edges arrive in one frame, word_o carries the last 16 bits received.
- R6: A frame with fewer than 16 rising edges (zero, 10 or 15) produces no strobe.
- R7: A frame sent as two 8-bit bursts, with the select held low through a pause between them, yields one strobe and the joined word.
- R8: With out_mode_i = 1 (rising launch), after the k-th rising edge of a frame dout_o shows the bit that was in position 15-k of the previous word. It changes only after a qualified rising edge.
- R9: With out_mode_i = 0 (falling launch), dout_o keeps its value through the high phase that follows rising edge k. It takes the bit from position 15-k of the previous word only after the next falling edge.
- R10: A synchronous reset clears the shift register and the bit count, and drives dout_o and word_valid_o low. A reset in the middle of a frame discards the bits already received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| din_i | input | 1 | Serial data from the host, asynchronous |
| csn_i | input | 1 | Select, active low, asynchronous |
| out_mode_i | input | 1 | Launch edge for dout_o: 0 falling, 1 rising |
| word_o | output | 16 | Received command word |
| word_valid_o | output | 1 | One-cycle execute strobe, no back-pressure |
| dout_o | output | 1 | Chained serial output, last stage of the shift register |

## Verification
The hardest case to reach from the ports is the half-clock difference between the two launch modes. Both modes carry the same bit sequence, so comparing whole words cannot tell them apart. The stimulus therefore loads a known word, starts a second frame, and samples dout_o once at the end of each high phase and once at the end of each low phase. Falling launch must still show the previous bit in the high phase, while rising launch already shows the next one. Serial clock edges sent while the select is high, and a reset part-way through a frame, are followed by short frames. A strobe after such a frame would reveal a bit count that advanced when it should have been held or cleared.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
  typedef enum logic {
    LAUNCH_FALL = 1'b0,
    LAUNCH_RISE = 1'b1
  } launch_e;

  typedef struct packed {
    logic rise;     // qualified serial clock rising edge
    logic fall;     // qualified serial clock falling edge
    logic cs_rise;  // select released
    logic cs_high;  // select level, synchronized
  } sclk_evt_t;
endpackage

// File: rtl/cmd_rx_sync.sv
module cmd_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) stg_q[0] <= RST_VAL;
      else     stg_q[0] <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stg_q <= {STAGES{RST_VAL}};
      else     stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cmd_rx_shift.sv
module cmd_rx_shift
  import cmd_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  sclk_evt_t         evt_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] sr_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sr_q, word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (evt_i.cs_rise && cnt_q == FULL) begin
        valid_q <= 1'b1;
        word_q  <= sr_q;
      end
      if (evt_i.cs_high) begin
        cnt_q <= '0;
      end else if (evt_i.rise) begin
        sr_q <= {sr_q[WORD_W-2:0], din_i};
        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sr_o    = sr_q;
  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cmd_rx_dout.sv
module cmd_rx_dout
  import cmd_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  launch_e mode_i,
  input  logic    fall_i,
  input  logic    msb_i,
  output logic    dout_o
);
  logic late_q;

  always_ff @(posedge clk) begin
    if (rst)         late_q <= 1'b0;
    else if (fall_i) late_q <= msb_i;
  end

  assign dout_o = (mode_i == LAUNCH_RISE) ? msb_i : late_q;
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import cmd_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              csn_i,
  input  logic              out_mode_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              dout_o
);
  localparam int unsigned NSIG = 3;
  localparam logic [NSIG-1:0] IDLE = 3'b100; // {csn, din, sclk}

  logic [NSIG-1:0]   sync_s, prev_q;
  logic              sclk_s, din_s, csn_s;
  logic              sclk_rise, sclk_fall;
  logic [WORD_W-1:0] sr_q;
  sclk_evt_t         evt;

  cmd_rx_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i({csn_i, din_i, sclk_i}), .q_o(sync_s)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE;
    else     prev_q <= sync_s;
  end

  assign {csn_s, din_s, sclk_s} = sync_s;
  assign sclk_rise   = sclk_s & ~prev_q[0] & ~csn_s;
  assign sclk_fall   = ~sclk_s & prev_q[0] & ~csn_s;
  assign evt.rise    = sclk_rise;
  assign evt.fall    = sclk_fall;
  assign evt.cs_rise = csn_s & ~prev_q[2];
  assign evt.cs_high = csn_s;

  cmd_rx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .evt_i(evt), .din_i(din_s),
    .sr_o(sr_q), .word_o(word_o), .valid_o(word_valid_o)
  );

  cmd_rx_dout u_dout (
    .clk(clk), .rst(rst), .mode_i(launch_e'(out_mode_i)),
    .fall_i(sclk_fall), .msb_i(sr_q[WORD_W-1]), .dout_o(dout_o)
  );
endmodule

// File: rtl/serial_cmd_rx_sva.sv
module serial_cmd_rx_sva #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              out_mode_i,
  input logic              word_valid_o,
  input logic              dout_o,
  input logic              csn_s,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic [WORD_W-1:0] sr_q
);
  // R4: strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  // R4: strobe only once the select is released
  a_r4_after_release: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> csn_s);

  // R2: shift register frozen while select is high
  a_r2_frozen_idle: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> $stable(sr_q));

  // R8: rising launch changes only after a qualified rising edge
  a_r8_rise_launch: assert property (@(posedge clk) disable iff (rst)
    (out_mode_i && $past(out_mode_i) && !$past(rst) && !$stable(dout_o))
      |-> $past(sclk_rise));

  // R9: falling launch changes only after a qualified falling edge
  a_r9_fall_launch: assert property (@(posedge clk) disable iff (rst)
    (!out_mode_i && !$past(out_mode_i) && !$past(rst) && !$stable(dout_o))
      |-> $past(sclk_fall));

  // R10: reset leaves outputs quiet
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!word_valid_o && !dout_o));
endmodule

bind serial_cmd_rx serial_cmd_rx_sva #(.WORD_W(WORD_W)) u_sva (
  .clk(clk), .rst(rst), .out_mode_i(out_mode_i), .word_valid_o(word_valid_o),
  .dout_o(dout_o), .csn_s(csn_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .sr_q(sr_q)
);

// File: tb/serial_cmd_rx_bench.sv
module serial_cmd_rx_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, din = 1'b0, csn = 1'b1, mode = 1'b0;
  logic [15:0] word;
  logic valid, dout;
  int checks = 0, errors = 0, strobes = 0;
  logic [15:0] last_word = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_cmd_rx u_serial_cmd_rx (
    .clk(clk), .rst(rst), .sclk_i(sclk), .din_i(din), .csn_i(csn),
    .out_mode_i(mode), .word_o(word), .word_valid_o(valid), .dout_o(dout)
  );

  always @(negedge clk) if (valid) begin
    strobes++;
    last_word = word;
  end

  typedef struct packed {
    logic [5:0]  n;
    logic [31:0] bits;
    logic        exp_v;
    logic [15:0] exp_w;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{6'd16, 32'h0000_A5C3, 1'b1, 16'hA5C3},
    '{6'd16, 32'h0000_FFFF, 1'b1, 16'hFFFF},
    '{6'd16, 32'h0000_0001, 1'b1, 16'h0001},
    '{6'd20, 32'h000A_BCDE, 1'b1, 16'hBCDE},
    '{6'd17, 32'h0001_2345, 1'b1, 16'h2345},
    '{6'd10, 32'h0000_03FF, 1'b0, 16'h0000},
    '{6'd0,  32'h0000_0000, 1'b0, 16'h0000},
    '{6'd15, 32'h0000_7FFF, 1'b0, 16'h0000}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_pulse(input logic b, output logic hi, output logic lo);
    din = b;
    wait_clk(6);
    sclk = 1'b1;
    wait_clk(6);
    hi = dout;
    sclk = 1'b0;
    wait_clk(6);
    lo = dout;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic h, l;
    for (int i = n - 1; i >= 0; i--) bit_pulse(v[i], h, l);
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    csn = 1'b0;
    wait_clk(6);
    send_bits(v, n);
    wait_clk(6);
    csn = 1'b1;
    wait_clk(10);
  endtask

  task automatic lag_test(input logic m, input logic [15:0] w1);
    logic h, l;
    mode = m;
    frame({16'h0, w1}, 16);
    csn = 1'b0;
    wait_clk(6);
    for (int k = 1; k <= 15; k++) begin
      bit_pulse(1'b0, h, l);
      if (m) begin
        chk($sformatf("R8 rise-launch high phase k=%0d", k), h, w1[15-k]);
      end else begin
        chk($sformatf("R9 fall-launch high phase k=%0d", k), h, w1[16-k]);
        chk($sformatf("R9 fall-launch low phase k=%0d", k), l, w1[15-k]);
      end
    end
    send_bits(32'h0, 1);
    wait_clk(6);
    csn = 1'b1;
    wait_clk(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - errors, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R10: reset state
    chk("R10 dout after reset", dout, 1'b0);
    chk("R10 no strobe after reset", strobes, 0);

    // table: R1 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      s0 = strobes;
      frame(VECS[v].bits, int'(VECS[v].n));
      chk($sformatf("R4/R5/R6 strobe count vec %0d", v), strobes - s0, VECS[v].exp_v);
      if (VECS[v].exp_v)
        chk($sformatf("R3/R5 word vec %0d", v), last_word, VECS[v].exp_w);
      if (v == 0) begin
        chk("R1 address bit", last_word[15], 1'b1);
        chk("R1 control bits", last_word[14:13], 2'b01);
        chk("R1 data bits", last_word[12:0], 13'h05C3);
      end
    end

    // R7: two bursts with a pause
    s0 = strobes;
    csn = 1'b0;
    wait_clk(6);
    send_bits(32'h5A, 8);
    wait_clk(40);
    send_bits(32'h3C, 8);
    wait_clk(6);
    csn = 1'b1;
    wait_clk(10);
    chk("R7 one strobe for split frame", strobes - s0, 1);
    chk("R7 joined word", last_word, 16'h5A3C);

    // R2: edges with select high are ignored
    mode = 1'b1;
    frame(32'h1234, 16);
    chk("R8 dout shows msb after frame", dout, 1'b0);
    s0 = strobes;
    din = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_clk(6); sclk = 1'b1; wait_clk(6); sclk = 1'b0;
    end
    wait_clk(6);
    chk("R2 shift register unchanged (dout)", dout, 1'b0);
    chk("R2 no strobe from idle edges", strobes - s0, 0);
    frame(32'h7FFF, 15);
    chk("R2 count not advanced by idle edges", strobes - s0, 0);

    // R8 / R9: launch edge and lag
    lag_test(1'b1, 16'hC3A5);
    lag_test(1'b0, 16'hC3A5);

    // R10: reset clears shift register and bit count
    mode = 1'b1;
    frame(32'hFFFF, 16);
    chk("R8 dout high after all-ones frame", dout, 1'b1);
    rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(2);
    chk("R10 reset clears shift register", dout, 1'b0);
    s0 = strobes;
    csn = 1'b0;
    wait_clk(6);
    send_bits(32'h1F, 5);
    rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    send_bits(32'h7FF, 11);
    wait_clk(6);
    csn = 1'b1;
    wait_clk(10);
    chk("R10 mid-frame reset discards bits", strobes - s0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - errors, checks);
    $finish;
  end
endmodule